// File: doc/BRIEF.md
# Iterative Multiply, Multiply-Accumulate and Divide Unit

This block is a sequential arithmetic engine for unsigned operands of a parameterised word width (32 bits by default). One iterative datapath handles four operations: a product truncated to one word, a full double-width product split into high and low words, a product plus an addend, and an integer quotient with its remainder. Multiplication uses a shift-add scheme and division uses a restoring scheme. Each retires one operand bit per clock.

A client holds `start` high for one cycle while the unit is idle, with `opSel` and up to three operands (`opA`, `opB`, `opC`) valid in that cycle. The unit raises `busy`, iterates once per bit, and then pulses `done` for one cycle. In that cycle `resLo` and `resHi` carry the answer. The results stay on the outputs until the next accepted start. Any start that arrives while the unit is working is dropped.

Top module: `mulDivUnit`

## Requirements
- R1: With opSel = 0 the unit returns the low WIDTH bits of opA × opB on resLo and drives resHi to 0 (0x25 × 0x65 gives 0xE99).
- R2: With opSel = 1 the unit returns the full unsigned 2·WIDTH-bit product of opA × opB, with the upper half on resHi and the lower half on resLo (0x54000000 × 0x10000002 gives 0x05400000 and 0xA8000000).
- R3: With opSel = 2 the unit returns (opA × opB + opC) modulo 2^WIDTH on resLo and drives resHi to 0 (100 × 5 + 40 gives 540; the addition wraps).
- R4: With opSel = 3 the unit returns the quotient opA / opB, truncated toward zero, on resLo and the remainder on resHi (8 / 3 gives 2 remainder 2).
- R5: A divide with opB = 0 returns 0 on both resLo and resHi and completes with the same latency as any other operation.
- R6: A start is accepted at a rising edge where busy is low. busy is high from the next cycle on. done is high for exactly one cycle, WIDTH + 1 cycles after the accepting edge. busy is low in the cycle after done.
- R7: A start raised while busy is high has no effect on the result or on the timing of the operation in progress.
- R8: While reset is held and just after it, busy and done are 0 and resLo and resHi are 0.
- R9: After done, resLo and resHi keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when the unit is idle |
| opSel | input | 2 | Operation: 0 low product, 1 long product, 2 multiply-accumulate, 3 divide |
| opA | input | WIDTH | Multiplicand or dividend |
| opB | input | WIDTH | Multiplier or divisor |
| opC | input | WIDTH | Addend for multiply-accumulate |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| resLo | output | WIDTH | Low result word or quotient |
| resHi | output | WIDTH | High result word or remainder |

## Verification
The bench builds the unit at its default WIDTH of 32. At that width the worked values in the requirements can be used exactly as written. It also reaches the true 64-bit corner cases: an all-ones squared, a wrapping accumulate, a divisor larger than the dividend, and division by zero. It times each operation to the expected 33-cycle latency and injects a stray start part-way through one run.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'd0,
    OP_MULL = 2'd1,
    OP_MAC  = 2'd2,
    OP_DIV  = 2'd3
  } mduOp_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mduState_e;

  typedef struct packed {
    logic load;    // capture operands, clear partial result
    logic step;    // perform one bit iteration
    logic finish;  // apply the operation's final correction on this step
  } mduCtl_t;
endpackage

// File: rtl/mduCtrl.sv
module mduCtrl
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output mduCtl_t ctl,
  output logic    busy,
  output logic    done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  mduState_e stateQ;
  logic [CW-1:0] cntQ;
  logic lastStep;

  assign lastStep = (stateQ == ST_RUN) && (cntQ == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (start) begin
          stateQ <= ST_RUN;
          cntQ   <= '0;
        end
        ST_RUN: begin
          if (lastStep) stateQ <= ST_FIN;
          else          cntQ   <= cntQ + 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load   = (stateQ == ST_IDLE) && start;
    ctl.step   = (stateQ == ST_RUN);
    ctl.finish = lastStep;
    busy       = (stateQ != ST_IDLE);
    done       = (stateQ == ST_FIN);
  end
endmodule

// File: rtl/mduDatapath.sv
module mduDatapath
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mduCtl_t          ctl,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  output logic [WIDTH-1:0] resLo,
  output logic [WIDTH-1:0] resHi
);
  localparam int XW = WIDTH + 1;

  mduOp_e opQ, opIn;
  logic [WIDTH-1:0] hiQ, loQ, mcandQ, addQ;

  logic [XW-1:0]    mulSum, divShift, divDiff;
  logic             divFits;
  logic [WIDTH-1:0] stepHi, stepLo, nextHi, nextLo;

  assign opIn = mduOp_e'(opSel);

  // one bit of shift-add multiply or restoring divide
  always_comb begin
    mulSum   = {1'b0, hiQ} + (loQ[0] ? {1'b0, mcandQ} : '0);
    divShift = {hiQ, loQ[WIDTH-1]};
    divDiff  = divShift - {1'b0, mcandQ};
    divFits  = ~divDiff[XW-1];
    if (opQ == OP_DIV) begin
      stepHi = divFits ? divDiff[WIDTH-1:0] : divShift[WIDTH-1:0];
      stepLo = {loQ[WIDTH-2:0], divFits};
    end else begin
      stepHi = mulSum[XW-1:1];
      stepLo = {mulSum[0], loQ[WIDTH-1:1]};
    end
  end

  // final correction folded into the last iteration
  always_comb begin
    nextHi = stepHi;
    nextLo = stepLo;
    if (ctl.finish) begin
      case (opQ)
        OP_MUL: nextHi = '0;
        OP_MAC: begin
          nextHi = '0;
          nextLo = stepLo + addQ;
        end
        OP_DIV: if (mcandQ == '0) begin
          nextHi = '0;
          nextLo = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ    <= OP_MUL;
      hiQ    <= '0;
      loQ    <= '0;
      mcandQ <= '0;
      addQ   <= '0;
    end else if (ctl.load) begin
      opQ    <= opIn;
      hiQ    <= '0;
      loQ    <= (opIn == OP_DIV) ? opA : opB;
      mcandQ <= (opIn == OP_DIV) ? opB : opA;
      addQ   <= opC;
    end else if (ctl.step) begin
      hiQ <= nextHi;
      loQ <= nextLo;
    end
  end

  assign resLo = loQ;
  assign resHi = hiQ;
endmodule

// File: rtl/mulDivUnit.sv
module mulDivUnit
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] resLo,
  output logic [WIDTH-1:0] resHi
);
  mduCtl_t ctl;

  mduCtrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctl  (ctl),
    .busy (busy),
    .done (done)
  );

  mduDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .opSel(opSel),
    .opA  (opA),
    .opB  (opB),
    .opC  (opC),
    .resLo(resLo),
    .resHi(resHi)
  );
endmodule

// File: rtl/mduChecker.sv
module mduChecker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] resLo,
  input logic [WIDTH-1:0] resHi
);
  logic [15:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN)               runCnt <= '0;
    else if (!busy && start) runCnt <= '0;
    else if (busy)           runCnt <= runCnt + 1'b1;
  end

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);  // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R6
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runCnt == 16'(WIDTH)));  // R6
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);  // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);  // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(resLo) && $stable(resHi)));  // R9
endmodule

bind mulDivUnit mduChecker #(.WIDTH(WIDTH)) u_chk (
  .clk  (clk),
  .rstN (rstN),
  .start(start),
  .busy (busy),
  .done (done),
  .resLo(resLo),
  .resHi(resHi)
);

// File: tb/tb_mulDivUnit.sv
module tb_mulDivUnit;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] opSel = '0;
  logic [WIDTH-1:0] opA = '0, opB = '0, opC = '0;
  logic busy, done;
  logic [WIDTH-1:0] resLo, resHi;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mulDivUnit #(.WIDTH(WIDTH)) dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .opA(opA), .opB(opB), .opC(opC),
    .busy(busy), .done(done), .resLo(resLo), .resHi(resHi)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Runs one operation; if strayAt > 0 a foreign start is raised that many cycles in.
  task automatic runOp(input logic [1:0] op, input logic [WIDTH-1:0] a,
                       input logic [WIDTH-1:0] b, input logic [WIDTH-1:0] c,
                       input int strayAt);
    logic [63:0] prod;
    logic [WIDTH-1:0] expLo, expHi, keepLo, keepHi;
    string tag;
    int cyc;
    prod = 64'(a) * 64'(b);
    case (op)
      2'd0: begin tag = "R1"; expLo = prod[WIDTH-1:0]; expHi = '0; end
      2'd1: begin tag = "R2"; expLo = prod[WIDTH-1:0]; expHi = prod[2*WIDTH-1:WIDTH]; end
      2'd2: begin tag = "R3"; expLo = prod[WIDTH-1:0] + c; expHi = '0; end
      default: begin
        if (b == '0) begin tag = "R5"; expLo = '0; expHi = '0; end
        else begin tag = "R4"; expLo = a / b; expHi = a % b; end
      end
    endcase
    @(negedge clk);
    opSel = op; opA = a; opB = b; opC = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opSel = ~op; opA = ~a; opB = b + 1; opC = ~c;
    cyc = 1;
    while (!done && cyc < 100) begin
      if (cyc == strayAt) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    chk((strayAt > 0) ? "R7" : "R6", "latency", 64'(cyc), 64'(WIDTH + 1));
    chk(tag, "resLo", 64'(resLo), 64'(expLo));
    chk(tag, "resHi", 64'(resHi), 64'(expHi));
    if (strayAt > 0) chk("R7", "busy at done", 64'(busy), 64'd1);
    keepLo = resLo; keepHi = resHi;
    @(negedge clk);
    chk("R6", "done one cycle", 64'(done), 64'd0);
    chk("R6", "idle after done", 64'(busy), 64'd0);
    repeat (3) @(negedge clk);
    chk("R9", "hold lo", 64'(resLo), 64'(keepLo));
    chk("R9", "hold hi", 64'(resHi), 64'(keepHi));
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R8", "busy in reset", 64'(busy), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8", "busy", 64'(busy), 64'd0);
    chk("R8", "done", 64'(done), 64'd0);
    chk("R8", "resLo", 64'(resLo), 64'd0);
    chk("R8", "resHi", 64'(resHi), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    runOp(2'd0, 32'h25, 32'h65, 32'h0, 0);                 // R1 worked value
    runOp(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 0);   // R1 truncation
    runOp(2'd1, 32'h5400_0000, 32'h1000_0002, 32'h0, 0);   // R2 worked value
    runOp(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 0);   // R2 all ones
    runOp(2'd2, 32'd100, 32'd5, 32'd40, 0);                // R3 worked value
    runOp(2'd2, 32'hFFFF_FFFF, 32'h1, 32'h2, 0);           // R3 wrap
    runOp(2'd3, 32'd8, 32'd3, 32'h0, 0);                   // R4 worked value
    runOp(2'd3, 32'hFFFF_FFFF, 32'h10, 32'h0, 0);          // R4 large dividend
    runOp(2'd3, 32'd5, 32'd7, 32'h0, 0);                   // R4 divisor above dividend
    runOp(2'd3, 32'd1234, 32'd0, 32'h0, 0);                // R5 divide by zero
    runOp(2'd1, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0, 10);  // R7 stray start
    runOp(2'd3, 32'd1000, 32'd7, 32'h0, WIDTH);            // R7 stray start at last step
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule